// File: doc/BRIEF.md
# Strobe-Timed Register Bus Slave

This block is the peripheral side of a microprocessor bus on which transfers run with no relation to the local clock and are framed only by an active-low chip select. The select, the direction line, a five-bit register address and an eight-bit data bus all pass through two-flop synchronisers. A transfer begins when the synchronised select falls and ends when it rises again.

A read places the addressed register on the data bus and only then pulls the transfer acknowledge low. A write captures the bus and loads the register, then acknowledges. Addresses outside the implemented range still complete the handshake. A read of such an address returns all ones, and a write to one stores nothing.

When the select is released, the acknowledge is first driven high for one local clock, and then the acknowledge and the data bus are both tri-stated. The acknowledge and the data bus each have their own drive-value and output-enable signals. A small register file of eight entries is included so that the block can be exercised on its own. A select that arrives while the interrupt acknowledge is also low is an illegal combination, and the block ignores it.

Top module: `strobe_bus_slave`

## Requirements
- R1: After reset, both output enables are low and every implemented register reads 0x00.
- R2: A falling select with the direction line high (1 = read) starts a read. The selected register appears on data_o with data_oe_o high for at least one clock before dtack_o goes low with dtack_oe_o high.
- R3: A read of any address from 8 to 31 returns 0xFF.
- R4: A falling select with the direction line low (0 = write) loads data_i into the register at addresses 0 to 7, and the cycle is acknowledged.
- R5: A write to an address from 8 to 31 is acknowledged, and no register changes.
- R6: While the select stays low, the acknowledge stays driven low.
- R7: After the select rises, dtack_o is driven high with dtack_oe_o high for exactly one clock sample. In the next clock, dtack_oe_o and data_oe_o are both low.
- R8: A select that falls while iack_ni is low starts no cycle: there is no acknowledge, no drive and no write.
- R9: During a write cycle, data_oe_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| rw_i | input | 1 | Direction, 1 = read, 0 = write |
| iack_ni | input | 1 | Active-low interrupt acknowledge |
| addr_i | input | 5 | Register address |
| data_i | input | 8 | Data bus input |
| data_o | output | 8 | Data bus drive value |
| data_oe_o | output | 1 | Data bus output enable |
| dtack_o | output | 1 | Transfer acknowledge drive value, active low |
| dtack_oe_o | output | 1 | Transfer acknowledge output enable |

## Verification
The bench uses a seeded random mix of reads and writes over the full 32-address space, tracked against a bench model of the eight registers, together with directed corner cases.

- Reads at the implemented boundary (address 7 against 8) and at address 31 catch a design that mirrors the unimplemented space onto real registers instead of returning ones.
- Writes to unimplemented addresses followed by full readback catch a design that aliases those writes into the file.
- The release phase is sampled clock by clock. A design that drops the enable together with the select, or holds the high drive too long, misses the single high sample.
- A select paired with a low interrupt acknowledge would, in a faulty design, produce an acknowledge or a stray write. The bench looks for both.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_ACK,
    ST_REL
  } bus_state_e;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sbs_regfile.sv
module sbs_regfile #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
  logic w_hit, r_hit;

  assign w_hit = waddr_i < LIMIT;
  assign r_hit = raddr_i < LIMIT;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           mem_q[g] <= '0;
      else if (we_i && w_hit && waddr_i[IDX_W-1:0] == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  // unimplemented space reads as all ones
  assign rdata_o = r_hit ? mem_q[raddr_i[IDX_W-1:0]] : '1;

  p_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w_hit) |=> mem_q[$past(waddr_i[IDX_W-1:0])] == $past(wdata_i));

  p_no_store_unimpl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !w_hit) |=> $stable(mem_q));

  p_unimpl_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_hit |-> rdata_o == '1);
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int A_W = 5,
  parameter int D_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_s_i,
  input  logic           iack_s_i,
  input  logic           rw_s_i,
  input  logic [A_W-1:0] addr_s_i,
  input  logic [D_W-1:0] data_s_i,
  input  logic [D_W-1:0] rdata_i,
  output logic           we_o,
  output logic [A_W-1:0] waddr_o,
  output logic [D_W-1:0] wdata_o,
  output logic [D_W-1:0] data_o,
  output logic           data_oe_o,
  output logic           dtack_o,
  output logic           dtack_oe_o
);
  bus_state_e     state_q;
  logic           cs_prev_q, rd_q, start;
  logic [D_W-1:0] data_q;

  // illegal select+iack pairing never opens a cycle
  assign start = (state_q == ST_IDLE) && cs_prev_q && !cs_s_i && iack_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cs_prev_q <= 1'b1;
      rd_q      <= 1'b0;
      data_q    <= '0;
    end else begin
      cs_prev_q <= cs_s_i;
      unique case (state_q)
        ST_IDLE: if (start) begin
          rd_q    <= rw_s_i;
          state_q <= rw_s_i ? ST_DRIVE : ST_ACK;
          if (rw_s_i) data_q <= rdata_i;
        end
        ST_DRIVE: state_q <= ST_ACK;
        ST_ACK:   if (cs_s_i) state_q <= ST_REL;
        ST_REL:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign we_o       = start && !rw_s_i;
  assign waddr_o    = addr_s_i;
  assign wdata_o    = data_s_i;
  assign data_o     = data_q;
  assign data_oe_o  = rd_q && (state_q != ST_IDLE);
  assign dtack_oe_o = (state_q == ST_ACK) || (state_q == ST_REL);
  assign dtack_o    = (state_q != ST_ACK);

  p_data_before_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dtack_oe_o && !dtack_o && !$past(dtack_oe_o) && rd_q) |-> $past(data_oe_o));

  p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dtack_oe_o && !dtack_o && !cs_s_i) |=> (dtack_oe_o && !dtack_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dtack_oe_o && dtack_o) |=> (!dtack_oe_o && !data_oe_o));

  p_illegal_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !iack_s_i) |=> (state_q == ST_IDLE && !we_o));

  p_write_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !data_oe_o);
endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
  import sbs_pkg::*;
#(
  parameter int A_W  = ADDR_W,
  parameter int D_W  = DATA_W,
  parameter int NREG = NUM_REGS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           rw_i,
  input  logic           iack_ni,
  input  logic [A_W-1:0] addr_i,
  input  logic [D_W-1:0] data_i,
  output logic [D_W-1:0] data_o,
  output logic           data_oe_o,
  output logic           dtack_o,
  output logic           dtack_oe_o
);
  localparam int BUS_W = 1 + A_W + D_W;

  logic [1:0]       strb_s;
  logic [BUS_W-1:0] bus_s;
  logic             we;
  logic [A_W-1:0]   waddr;
  logic [D_W-1:0]   wdata, rdata;

  sbs_sync #(.W(2), .RST_VAL(2'b11)) u_sync_strb (
    .clk_i, .rst_ni, .d_i({cs_ni, iack_ni}), .q_o(strb_s)
  );

  sbs_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({rw_i, addr_i, data_i}), .q_o(bus_s)
  );

  sbs_regfile #(.ADDR_W(A_W), .DATA_W(D_W), .NUM_REGS(NREG)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(bus_s[D_W +: A_W]), .rdata_o(rdata)
  );

  sbs_ctrl #(.A_W(A_W), .D_W(D_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_s_i(strb_s[1]), .iack_s_i(strb_s[0]),
    .rw_s_i(bus_s[BUS_W-1]), .addr_s_i(bus_s[D_W +: A_W]), .data_s_i(bus_s[D_W-1:0]),
    .rdata_i(rdata),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .data_o, .data_oe_o, .dtack_o, .dtack_oe_o
  );
endmodule

// File: tb/strobe_bus_slave_bench.sv
module strobe_bus_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rw = 1'b1, iack_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       data_oe, dtack, dtack_oe;

  int unsigned n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [7:0]  model [8];

  always #2.5 clk = ~clk;

  strobe_bus_slave u_strobe_bus_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .iack_ni(iack_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(data_oe),
    .dtack_o(dtack), .dtack_oe_o(dtack_oe)
  );

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    return (a < 5'd8) ? model[a[2:0]] : 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ack low seen; hold, then release and check R6/R7
  task automatic finish_cycle(input bit is_rd);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dtack_oe && !dtack, "R6", {dtack_oe, dtack}, 2'b10);
    end
    cs_n = 1'b1;
    begin
      int k = 0;
      while (!(dtack_oe && dtack) && k < 12) begin
        @(negedge clk);
        k++;
      end
      check(dtack_oe && dtack, "R7", {dtack_oe, dtack}, 2'b11);
      check(data_oe == is_rd, "R7", data_oe, is_rd);
    end
    @(negedge clk);
    check(!dtack_oe && !data_oe, "R7", {dtack_oe, data_oe}, 2'b00);
    idle(3);
  endtask

  task automatic bus_read(input logic [4:0] a, input string req);
    bit prev_oe = 1'b0;
    int k = 0;
    @(negedge clk);
    rw = 1'b1; addr = a; cs_n = 1'b0;
    while (!(dtack_oe && !dtack) && k < 12) begin
      prev_oe = data_oe;
      @(negedge clk);
      k++;
    end
    check(dtack_oe && !dtack, "R2", {dtack_oe, dtack}, 2'b10);
    check(prev_oe, "R2", prev_oe, 1'b1);
    check(data_oe && dout == exp_read(a), req, dout, exp_read(a));
    finish_cycle(1'b1);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d, input string req);
    bit drove = 1'b0;
    int k = 0;
    @(negedge clk);
    rw = 1'b0; addr = a; din = d; cs_n = 1'b0;
    while (!(dtack_oe && !dtack) && k < 12) begin
      if (data_oe) drove = 1'b1;
      @(negedge clk);
      k++;
    end
    check(dtack_oe && !dtack, req, {dtack_oe, dtack}, 2'b10);
    check(!drove && !data_oe, "R9", drove, 1'b0);
    if (a < 5'd8) model[a[2:0]] = d;
    finish_cycle(1'b0);
  endtask

  task automatic illegal(input bit is_rd, input logic [4:0] a, input logic [7:0] d);
    bit seen = 1'b0;
    @(negedge clk);
    rw = is_rd; addr = a; din = d; iack_n = 1'b0; cs_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dtack_oe || data_oe) seen = 1'b1;
    end
    check(!seen, "R8", seen, 1'b0);
    cs_n = 1'b1; iack_n = 1'b1;
    idle(4);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    idle(3);
    check(!dtack_oe && !data_oe, "R1", {dtack_oe, data_oe}, 2'b00);
    rst_n = 1'b1;
    idle(3);
    check(!dtack_oe && !data_oe, "R1", {dtack_oe, data_oe}, 2'b00);
    for (int i = 0; i < 8; i++) bus_read(5'(i), "R1");

    for (int i = 0; i < 8; i++) bus_write(5'(i), 8'(8'hA0 + i * 8'h11), "R4");
    for (int i = 0; i < 8; i++) bus_read(5'(i), "R4");
    bus_read(5'd8, "R3");
    bus_read(5'd31, "R3");
    bus_write(5'd8, 8'h5A, "R5");
    bus_write(5'd31, 8'hC3, "R5");
    bus_write(5'd15, 8'h00, "R5");
    for (int i = 0; i < 8; i++) bus_read(5'(i), "R5");

    illegal(1'b0, 5'd3, 8'hEE);
    bus_read(5'd3, "R8");
    illegal(1'b1, 5'd5, 8'h00);
    bus_read(5'd5, "R8");

    for (int t = 0; t < 80; t++) begin
      logic [4:0] a = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) bus_read(a, (a < 5'd8) ? "R2" : "R3");
      else bus_write(a, 8'($urandom), (a < 5'd8) ? "R4" : "R5");
    end
    for (int i = 0; i < 8; i++) bus_read(5'(i), "R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule